// File: doc/BRIEF.md
# Memory-Mapped Serial Receive Register Block

This block is the register-facing half of a simple serial port. A bus master reaches it through a word-addressed register window. From that window the master can drain received bytes from a circular receive queue, see how full the queue is, and send a byte straight out through a one-cycle transmit strobe. The master also sets the enables that drive a single level interrupt. Received bytes arrive on a byte-wide valid/ready input. A companion receive-DMA engine reports how many bytes it still expects. While that number is non-zero, incoming bytes go past the queue and out on a hand-off port to the DMA engine. Once the number reaches zero, bytes land in the queue again.

Line framing, baud timing and the memory side of DMA belong to neighbouring blocks. This block only steers bytes, holds the queue and produces the interrupt.

Top module: `serial_rx_regs`

## Requirements
- R1: After synchronous reset the queue is empty, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: A read of register index 1 (DATA) returns the oldest queued byte, zero-extended to 32 bits, and removes it. Bytes come out in arrival order, including across the wrap of the circular storage.
- R3: A read of DATA while the queue is empty returns 32'hFFFF_FFFF and leaves the occupancy at 0.
- R4: Index 0 reads the identifier constant (default 32'h5EA1_0001). Index 2 reads the current occupancy. Index 8 reads the queue depth (default 16). Index 7 reads the DMA outstanding count input.
- R5: Only address bits [11:2] select the register: offset 0x1008 behaves exactly like offset 0x008.
- R6: With no DMA outstanding, `rx_ready` is low when the queue holds DEPTH bytes, and a byte offered then is not stored.
- R7: While `dma_rem` is non-zero, `rx_ready` is high, an offered byte appears on `dma_byte_valid`/`dma_byte_data` in the same cycle, and the queue occupancy does not change.
- R8: Enable bit 0 of index 3 (IEN) raises `irq` while the queue is non-empty.
- R9: IEN bit 1 raises `irq` unconditionally.
- R10: IEN bit 2 raises `irq` while `dma_rem` is zero. `irq` is registered and follows a change in its inputs one cycle later.
- R11: A write to DATA produces one cycle of `tx_valid` on the next cycle, carrying the low byte of the written value on `tx_data`.
- R12: Reads of indices other than 0, 1, 2, 3, 7 and 8 return 0. Writes to them change neither IEN nor the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe; a DATA read pops at the clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 32 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte |
| dma_rem | input | 32 | Receive DMA bytes still outstanding |
| dma_byte_valid | output | 1 | Byte handed to the DMA path |
| dma_byte_data | output | 8 | Byte handed to the DMA path |
| tx_valid | output | 1 | Transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a full queue whose read position has already wrapped. Only there do the full-queue refusal and the modulo slot arithmetic both matter. The stimulus first pushes and drains a batch so that the read position lands mid-array. It then pushes until `rx_ready` drops, offers one more byte that must be refused, and drains all DEPTH entries against the scoreboard. The DMA bypass is reached by driving `dma_rem` non-zero around a byte offer.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [9:0] {
        IDX_IDENT  = 10'd0,
        IDX_DATA   = 10'd1,
        IDX_LEVEL  = 10'd2,
        IDX_IEN    = 10'd3,
        IDX_DMAREM = 10'd7,
        IDX_DEPTH  = 10'd8
    } reg_idx_e;

    localparam int IEN_NONEMPTY = 0;
    localparam int IEN_FORCE    = 1;
    localparam int IEN_DMA_DONE = 2;

    localparam logic [31:0] EMPTY_READ = 32'hFFFF_FFFF;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [9:0]  idx;
        logic [31:0] wdata;
    } bus_req_t;

    function automatic logic [9:0] addr_to_idx(input logic [31:0] addr);
        return addr[11:2];
    endfunction

endpackage

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

    logic [7:0]    store [DEPTH];
    logic [PW-1:0] pos_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   slot_sum;
    logic [CW:0]   slot_mod;
    logic          do_pop;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign count  = cnt_q;
    assign head   = store[pos_q];
    assign do_pop = pop && !empty;

    always_comb begin
        slot_sum = (CW+1)'(pos_q) + (CW+1)'(cnt_q);
        slot_mod = (slot_sum >= DEPTH_W) ? slot_sum - DEPTH_W : slot_sum;
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            store[PW'(slot_mod)] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            cnt_q <= '0;
        end else begin
            if (do_pop) begin
                pos_q <= (pos_q == PW'(DEPTH - 1)) ? '0 : pos_q + 1'b1;
            end
            case ({push && !full, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/srx_irq.sv
module srx_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ien,
    input  logic       fifo_nonempty,
    input  logic       dma_idle,
    output logic       irq
);
    import srx_pkg::*;

    logic level;

    always_comb begin
        level = (ien[IEN_NONEMPTY] && fifo_nonempty)
              || ien[IEN_FORCE]
              || (ien[IEN_DMA_DONE] && dma_idle);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= level;
    end
endmodule

// File: rtl/srx_regfile.sv
module srx_regfile #(
    parameter int          DEPTH    = 16,
    parameter logic [31:0] ID_VALUE = 32'h5EA1_0001,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  srx_pkg::bus_req_t req,
    input  logic [7:0]       head,
    input  logic [CW-1:0]    count,
    input  logic             empty,
    input  logic [31:0]      dma_rem,
    output logic             pop,
    output logic [31:0]      ien,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic [31:0]      rdata
);
    import srx_pkg::*;

    logic [31:0] ien_q;

    assign ien = ien_q;
    assign pop = req.rd && (req.idx == IDX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q    <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= req.wr && (req.idx == IDX_DATA);
            if (req.wr && req.idx == IDX_DATA) tx_data <= req.wdata[7:0];
            if (req.wr && req.idx == IDX_IEN)  ien_q   <= req.wdata;
        end
    end

    always_comb begin
        unique case (req.idx)
            IDX_IDENT:  rdata = ID_VALUE;
            IDX_DATA:   rdata = empty ? EMPTY_READ : {24'd0, head};
            IDX_LEVEL:  rdata = 32'(count);
            IDX_IEN:    rdata = ien_q;
            IDX_DMAREM: rdata = dma_rem;
            IDX_DEPTH:  rdata = 32'(DEPTH);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs #(
    parameter int          DEPTH    = 16,
    parameter logic [31:0] ID_VALUE = 32'h5EA1_0001,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    input  logic [31:0] dma_rem,
    output logic        dma_byte_valid,
    output logic [7:0]  dma_byte_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        irq
);
    import srx_pkg::*;

    bus_req_t      req;
    logic [7:0]    head;
    logic [CW-1:0] fifo_count;
    logic          full, empty, pop, dma_busy;
    logic [31:0]   ien_q;
    logic          unused_bits;

    assign unused_bits = ^{reg_addr[31:12], reg_addr[1:0], ien_q[31:3]};

    assign req.rd    = reg_rd;
    assign req.wr    = reg_wr;
    assign req.idx   = addr_to_idx(reg_addr);
    assign req.wdata = reg_wdata;

    assign dma_busy       = (dma_rem != '0);
    assign rx_ready       = dma_busy || !full;
    assign dma_byte_valid = rx_valid && dma_busy;
    assign dma_byte_data  = rx_data;

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(rx_valid && !dma_busy), .push_data(rx_data),
        .pop(pop), .head(head), .count(fifo_count),
        .full(full), .empty(empty)
    );

    srx_regfile #(.DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst(rst), .req(req),
        .head(head), .count(fifo_count), .empty(empty), .dma_rem(dma_rem),
        .pop(pop), .ien(ien_q),
        .tx_valid(tx_valid), .tx_data(tx_data), .rdata(reg_rdata)
    );

    srx_irq u_irq (
        .clk(clk), .rst(rst), .ien(ien_q[2:0]),
        .fifo_nonempty(!empty), .dma_idle(!dma_busy), .irq(irq)
    );
endmodule

// File: rtl/serial_rx_regs_chk.sv
module serial_rx_regs_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [31:0]   reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [31:0]   dma_rem,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          irq,
    input logic [CW-1:0] fifo_count,
    input logic [31:0]   ien
);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    a_r6_full_refuses: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == CW'(DEPTH) && dma_rem == 0) |-> !rx_ready);

    a_r7_bypass_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && dma_rem != 0) |=> fifo_count <= $past(fifo_count));

    a_r3_empty_all_ones: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[11:2] == 10'd1 && fifo_count == 0) |-> reg_rdata == 32'hFFFF_FFFF);

    a_r11_tx_strobe: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[11:2] == 10'd1) |=> (tx_valid && tx_data == $past(reg_wdata[7:0])));

    a_r9_force_irq: assert property (@(posedge clk) disable iff (rst)
        ien[1] |=> irq);
endmodule

bind serial_rx_regs serial_rx_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .dma_rem(dma_rem),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
    .fifo_count(fifo_count), .ien(ien_q)
);

// File: tb/serial_rx_regs_test.sv
module serial_rx_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_rd = 0, reg_wr = 0;
    logic [31:0] reg_addr = 0, reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = 0;
    logic        rx_ready;
    logic [31:0] dma_rem = 0;
    logic        dma_byte_valid;
    logic [7:0]  dma_byte_data;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    logic [7:0] tx_q[$];
    logic [31:0] rv;

    always #10 clk = ~clk;

    serial_rx_regs uut (
        .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .dma_rem(dma_rem), .dma_byte_valid(dma_byte_valid),
        .dma_byte_data(dma_byte_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #2 v = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        if (a[11:2] == 10'd1) tx_q.push_back(d[7:0]);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        #2 if (rx_ready && dma_rem == 0) exp_q.push_back(b);
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic pop_chk(input string req);
        logic [31:0] e;
        e = (exp_q.size() == 0) ? 32'hFFFF_FFFF : {24'd0, exp_q.pop_front()};
        rd(32'h4, rv);
        chk(req, rv, e);
    endtask

    task automatic irq_chk(input string req, input logic e);
        repeat (3) @(negedge clk);
        chk(req, {31'd0, irq}, {31'd0, e});
    endtask

    // transmit monitor (R11)
    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            if (tx_q.size() == 0) chk("R11 unexpected tx", {24'd0, tx_data}, 32'hx);
            else chk("R11 tx byte", {24'd0, tx_data}, {24'd0, tx_q.pop_front()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 rx_ready", {31'd0, rx_ready}, 1);
        rd(32'h8, rv);  chk("R1 level", rv, 0);

        rd(32'h0, rv);  chk("R4 ident", rv, 32'h5EA1_0001);
        rd(32'h20, rv); chk("R4 depth", rv, 16);

        pop_chk("R3 empty read");
        rd(32'h8, rv);  chk("R3 level stays 0", rv, 0);

        send(8'h11); send(8'h22); send(8'h33);
        rd(32'h8, rv);  chk("R4 level 3", rv, 3);
        repeat (3) pop_chk("R2 order");

        for (int i = 0; i < 10; i++) send(8'h40 + 8'(i));
        for (int i = 0; i < 10; i++) pop_chk("R2 order");
        for (int i = 0; i < 16; i++) send(8'hA0 + 8'(i));
        chk("R6 full not ready", {31'd0, rx_ready}, 0);
        send(8'hEE);
        rd(32'h8, rv);  chk("R6 level 16", rv, 16);
        for (int i = 0; i < 16; i++) pop_chk("R2 wrap order");
        pop_chk("R6 extra not stored");

        dma_rem = 5;
        @(negedge clk);
        rx_valid = 1; rx_data = 8'h5C;
        #2;
        chk("R7 ready", {31'd0, rx_ready}, 1);
        chk("R7 handoff valid", {31'd0, dma_byte_valid}, 1);
        chk("R7 handoff data", {24'd0, dma_byte_data}, 32'h5C);
        @(negedge clk);
        rx_valid = 0;
        rd(32'h8, rv);  chk("R7 level unchanged", rv, 0);
        rd(32'h1C, rv); chk("R4 dma remain", rv, 5);

        wr(32'hC, 32'h1);
        irq_chk("R8 empty no irq", 0);
        dma_rem = 0;
        send(8'h77);
        irq_chk("R8 nonempty irq", 1);
        pop_chk("R2 single");
        irq_chk("R8 drained irq low", 0);

        wr(32'hC, 32'h2);
        irq_chk("R9 force", 1);

        wr(32'hC, 32'h4);
        irq_chk("R10 dma idle", 1);
        dma_rem = 3;
        irq_chk("R10 dma busy", 0);
        dma_rem = 0;

        wr(32'h100C, 32'h0);
        rd(32'h0C, rv); chk("R5 aliased write", rv, 0);
        send(8'h99);
        rd(32'h1008, rv); chk("R5 aliased level", rv, 1);
        pop_chk("R5 pop");

        wr(32'h4, 32'h1234_56A5);
        wr(32'h1004, 32'h0000_003C);
        repeat (3) @(negedge clk);
        chk("R11 all sent", tx_q.size(), 0);

        send(8'h61);
        wr(32'h24, 32'h7);
        wr(32'h30, 32'h7);
        rd(32'h24, rv); chk("R12 unmapped read", rv, 0);
        rd(32'h10, rv); chk("R12 idx4 read", rv, 0);
        rd(32'hC, rv);  chk("R12 ien unchanged", rv, 0);
        rd(32'h8, rv);  chk("R12 level unchanged", rv, 1);
        pop_chk("R12 data intact");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule